// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block is the data mover behind a memory-card host controller. When a data command is issued with DMA switched on, it walks a linked list of descriptors in system memory. Each descriptor names a buffer and a length. The engine streams that buffer's bytes to the card data port on a transmit, or fills the buffer from the card on a receive. It then hands the descriptor back to software and goes on to the next one.

A descriptor is four 32-bit words at consecutive addresses. Word 0 holds control and status, word 1 the buffer length, word 2 the buffer address, and word 3 the address of the following descriptor. In word 0, bit 31 marks the descriptor as owned by the engine, bit 2 flags the final descriptor in the list, and bits 30, 4, 3 and 1 are carried through without being acted on. Memory is reached through a word-wide request/acknowledge port. The card side uses byte-wide valid/ready streams, one for each direction.

When a walk finishes, the engine emits a one-cycle completion event, which the host controller uses to raise its raw data-complete and SDIO interrupt bits, and it sets bits in a 10-bit DMA status register. Software clears that register by writing ones to the bits it wants cleared.

Top module: `sdd_chain_dma`

## Requirements
- R1: A walk starts at the descriptor base and reads the four descriptor words in order from consecutive word addresses (base+0, +4, +8, +12). After each descriptor it continues at the address held in word 3.
- R2: A buffer length of zero is taken as the maximum length MAX_BYTES.
- R3: A buffer length larger than MAX_BYTES is clamped to MAX_BYTES.
- R4: Each descriptor moves exactly min(effective length, remaining byte count) bytes, and the remaining count drops by that amount.
- R5: Bits 1:0 of the buffer address are ignored. Bytes map little-endian into each memory word, with byte k of the buffer at bits 8*(k%4)+7 : 8*(k%4) of word k/4. On receive, the lanes of a final partial word that were not filled are written as zero.
- R6: When a descriptor's data has been moved, word 0 is written back to the descriptor address with bit 31 cleared and every other bit unchanged.
- R7: The walk ends after a descriptor whose bit 2 is set, or when the remaining count reaches zero. Descriptors after that point are not touched.
- R8: A start is ignored (no memory access and no completion) if DMA enable is low, the byte count is zero, the block size is zero, or, on a receive, the card reports no data ready.
- R9: At the end of a walk, done_o pulses for one cycle. Status bit 8 is set, together with bit 0 for a transmit or bit 1 for a receive.
- R10: A status clear write clears exactly the status bits whose mask bit is one. The other bits keep their value.
- R11: A memory request holds its address, direction and data until it is acknowledged. A card transmit byte holds its data until it is accepted.
- R12: After reset the engine is idle: no memory request, no card handshake active, and a status value of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: a data command has been loaded |
| dma_en_i | input | 1 | DMA enable from global control |
| is_write_i | input | 1 | 1 = memory to card (transmit), 0 = card to memory |
| card_rd_ready_i | input | 1 | Card has receive data available |
| desc_base_i | input | 32 | Address of the first descriptor (word aligned) |
| byte_count_i | input | 32 | Total bytes for the command |
| block_size_i | input | 32 | Block size; zero blocks the start |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the accessed word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Card accepts transmit byte |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Engine accepts receive byte |
| st_clr_we_i | input | 1 | Status clear strobe |
| st_clr_mask_i | input | 10 | Bits to clear when strobed |
| dma_status_o | output | 10 | DMA status (bit 8 summary, bit 0 transmit, bit 1 receive) |
| done_o | output | 1 | One-cycle completion event |
| busy_o | output | 1 | Walk in progress |

## Verification
The handshake assertions assume a memory port that answers every request with one acknowledge pulse, and a card port that may stall for any number of cycles. The alignment assertion also assumes the descriptor base and the next-pointers are word aligned. The bench's memory model acknowledges every other cycle, and its card models stall on a rotating pattern. Every descriptor address it lays out is a multiple of 16, while buffer addresses are given deliberately misaligned low bits, which the engine has to discard.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_MRD, S_TX, S_RX, S_MWR, S_WBACK, S_DONE
  } dma_state_e;

  localparam int HOLD_BIT = 31;
  localparam int LAST_BIT = 2;
  localparam int ST_W     = 10;
  localparam int ST_SUM   = 8;
  localparam int ST_TX    = 0;
  localparam int ST_RX    = 1;
endpackage

// File: rtl/sdd_len_calc.sv
// Effective per-descriptor byte count: zero or oversize lengths become the
// maximum, and the result never exceeds what is left of the command.
module sdd_len_calc #(
  parameter int MAX_BYTES = 8192,
  parameter int LEN_W     = 14
) (
  input  logic [31:0]      size_i,
  input  logic [31:0]      remain_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [31:0] MAX32 = 32'(MAX_BYTES);

  logic [31:0] clamp;

  always_comb begin
    clamp = ((size_i == 32'd0) || (size_i > MAX32)) ? MAX32 : size_i;
    len_o = LEN_W'((remain_i < clamp) ? remain_i : clamp);
  end
endmodule

// File: rtl/sdd_stage.sv
// One-word staging buffer between the word memory port and the byte card port.
module sdd_stage (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        load_i,
  input  logic [31:0] load_word_i,
  input  logic        put_i,
  input  logic [1:0]  idx_i,
  input  logic [7:0]  put_byte_i,
  output logic [31:0] word_o,
  output logic [7:0]  byte_o
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane_q, lane_n;
    logic       lane_en;

    always_comb begin
      lane_en = clr_i || load_i || (put_i && (idx_i == 2'(g)));
      if (clr_i)       lane_n = 8'd0;
      else if (load_i) lane_n = load_word_i[8*g +: 8];
      else             lane_n = put_byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= 8'd0;
      else if (lane_en) lane_q <= lane_n;
    end

    assign word_o[8*g +: 8] = lane_q;
  end

  assign byte_o = word_o[8*idx_i +: 8];
endmodule

// File: rtl/sdd_status.sv
// DMA status register: set on completion, write-one-to-clear from software.
module sdd_status
  import sdd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic            tx_dir_i,
  input  logic            clr_we_i,
  input  logic [ST_W-1:0] clr_mask_i,
  output logic [ST_W-1:0] q_o
);
  logic [ST_W-1:0] q_n, set_bits;
  logic            q_en;

  always_comb begin
    set_bits = '0;
    set_bits[ST_SUM] = 1'b1;
    if (tx_dir_i) set_bits[ST_TX] = 1'b1;
    else          set_bits[ST_RX] = 1'b1;
    q_en = set_i || clr_we_i;
    q_n  = q_o & ~(clr_we_i ? clr_mask_i : '0);
    if (set_i) q_n = q_n | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (q_en) q_o <= q_n;
  end

  a_r9_sum_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o[ST_SUM]);
  a_r10_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_i && clr_mask_i[ST_SUM]) |=> !q_o[ST_SUM]);
  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_i && !clr_mask_i[ST_TX] && q_o[ST_TX]) |=> q_o[ST_TX]);
endmodule

// File: rtl/sdd_chain_dma.sv
module sdd_chain_dma
  import sdd_pkg::*;
#(
  parameter int MAX_BYTES = 8192
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dma_en_i,
  input  logic            is_write_i,
  input  logic            card_rd_ready_i,
  input  logic [31:0]     desc_base_i,
  input  logic [31:0]     byte_count_i,
  input  logic [31:0]     block_size_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [31:0]     mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [31:0]     mem_rdata_i,
  output logic            tx_valid_o,
  output logic [7:0]      tx_data_o,
  input  logic            tx_ready_i,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_data_i,
  output logic            rx_ready_o,
  input  logic            st_clr_we_i,
  input  logic [ST_W-1:0] st_clr_mask_i,
  output logic [ST_W-1:0] dma_status_o,
  output logic            done_o,
  output logic            busy_o
);
  localparam int LEN_W = $clog2(MAX_BYTES) + 1;

  dma_state_e       state_q, state_n;
  logic [1:0]       widx_q, widx_n, bidx_q, bidx_n;
  logic [31:0]      desc_q, desc_n, remain_q, remain_n;
  logic [31:0]      dstat_q, dsize_q, dbuf_q, dnext_q;
  logic [LEN_W-1:0] off_q, off_n, off_m1, len_c;
  logic             wr_q, wr_n;
  logic             go, fetch_ld, stg_clr, stg_load, stg_put, st_set;
  logic [31:0]      buf_al, stg_word;
  logic [7:0]       stg_byte;

  sdd_len_calc #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_len (
    .size_i(dsize_q), .remain_i(remain_q), .len_o(len_c));

  sdd_stage u_stage (
    .clk(clk), .rst_n(rst_n), .clr_i(stg_clr), .load_i(stg_load),
    .load_word_i(mem_rdata_i), .put_i(stg_put), .idx_i(bidx_q),
    .put_byte_i(rx_data_i), .word_o(stg_word), .byte_o(stg_byte));

  sdd_status u_status (
    .clk(clk), .rst_n(rst_n), .set_i(st_set), .tx_dir_i(wr_q),
    .clr_we_i(st_clr_we_i), .clr_mask_i(st_clr_mask_i), .q_o(dma_status_o));

  assign go = start_i && dma_en_i && (byte_count_i != 32'd0) &&
              (block_size_i != 32'd0) && (is_write_i || card_rd_ready_i);
  assign fetch_ld = (state_q == S_FETCH) && mem_ack_i;

  // Next-state logic
  always_comb begin
    state_n  = state_q;
    widx_n   = widx_q;
    bidx_n   = bidx_q;
    desc_n   = desc_q;
    remain_n = remain_q;
    off_n    = off_q;
    wr_n     = wr_q;
    stg_clr  = 1'b0;
    stg_load = 1'b0;
    stg_put  = 1'b0;
    st_set   = 1'b0;
    case (state_q)
      S_IDLE: if (go) begin
        desc_n   = desc_base_i;
        remain_n = byte_count_i;
        wr_n     = is_write_i;
        widx_n   = 2'd0;
        state_n  = S_FETCH;
      end
      S_FETCH: if (mem_ack_i) begin
        widx_n = widx_q + 2'd1;
        if (widx_q == 2'd3) begin
          off_n   = '0;
          bidx_n  = 2'd0;
          stg_clr = 1'b1;
          state_n = wr_q ? S_MRD : S_RX;
        end
      end
      S_MRD: if (mem_ack_i) begin
        stg_load = 1'b1;
        state_n  = S_TX;
      end
      S_TX: if (tx_ready_i) begin
        off_n  = off_q + 1'b1;
        bidx_n = bidx_q + 2'd1;
        if (off_q + 1'b1 == len_c) state_n = S_WBACK;
        else if (bidx_q == 2'd3)   state_n = S_MRD;
      end
      S_RX: if (rx_valid_i) begin
        stg_put = 1'b1;
        off_n   = off_q + 1'b1;
        bidx_n  = bidx_q + 2'd1;
        if ((off_q + 1'b1 == len_c) || (bidx_q == 2'd3)) state_n = S_MWR;
      end
      S_MWR: if (mem_ack_i) begin
        stg_clr = 1'b1;
        state_n = (off_q == len_c) ? S_WBACK : S_RX;
      end
      S_WBACK: if (mem_ack_i) begin
        remain_n = remain_q - 32'(len_c);
        if (dstat_q[LAST_BIT] || (remain_q == 32'(len_c))) begin
          state_n = S_DONE;
        end else begin
          desc_n  = dnext_q;
          widx_n  = 2'd0;
          state_n = S_FETCH;
        end
      end
      S_DONE: begin
        st_set  = 1'b1;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      widx_q   <= 2'd0;
      bidx_q   <= 2'd0;
      desc_q   <= '0;
      remain_q <= '0;
      off_q    <= '0;
      wr_q     <= 1'b0;
    end else begin
      state_q  <= state_n;
      widx_q   <= widx_n;
      bidx_q   <= bidx_n;
      desc_q   <= desc_n;
      remain_q <= remain_n;
      off_q    <= off_n;
      wr_q     <= wr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dstat_q <= '0;
      dsize_q <= '0;
      dbuf_q  <= '0;
      dnext_q <= '0;
    end else if (fetch_ld) begin
      case (widx_q)
        2'd0:    dstat_q <= mem_rdata_i;
        2'd1:    dsize_q <= mem_rdata_i;
        2'd2:    dbuf_q  <= mem_rdata_i;
        default: dnext_q <= mem_rdata_i;
      endcase
    end
  end

  // Output decode
  always_comb begin
    buf_al      = {dbuf_q[31:2], 2'b00};
    off_m1      = off_q - 1'b1;
    mem_req_o   = (state_q == S_FETCH) || (state_q == S_MRD) ||
                  (state_q == S_MWR) || (state_q == S_WBACK);
    mem_we_o    = (state_q == S_MWR) || (state_q == S_WBACK);
    mem_wdata_o = (state_q == S_WBACK) ? (dstat_q & ~(32'd1 << HOLD_BIT)) : stg_word;
    case (state_q)
      S_FETCH: mem_addr_o = desc_q + {28'd0, widx_q, 2'b00};
      S_MRD:   mem_addr_o = buf_al + 32'({off_q[LEN_W-1:2], 2'b00});
      S_MWR:   mem_addr_o = buf_al + 32'({off_m1[LEN_W-1:2], 2'b00});
      S_WBACK: mem_addr_o = desc_q;
      default: mem_addr_o = '0;
    endcase
  end

  assign tx_valid_o = (state_q == S_TX);
  assign tx_data_o  = stg_byte;
  assign rx_ready_o = (state_q == S_RX);
  assign done_o     = (state_q == S_DONE);
  assign busy_o     = (state_q != S_IDLE);

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  a_r5_buf_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && ((state_q == S_MRD) || (state_q == S_MWR))) |-> (mem_addr_o[1:0] == 2'b00));
  a_r6_wb_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && (mem_addr_o == desc_q) && (state_q == S_WBACK))
      |-> !mem_wdata_o[HOLD_BIT]);
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o || rx_ready_o) |-> ((len_c != '0) && (32'(len_c) <= 32'(MAX_BYTES)) &&
                                    (off_q < len_c)));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !tx_valid_o && !rx_ready_o));
  a_r11_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid_o && rx_ready_o));
endmodule

// File: tb/sdd_chain_dma_tb.sv
module sdd_chain_dma_tb;
  localparam int MAXB = 16;

  logic        clk, rst_n, start, dma_en, is_write, card_rd_ready;
  logic [31:0] desc_base, byte_count, block_size;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]  tx_data, rx_data;
  logic        st_clr_we;
  logic [9:0]  st_clr_mask, dma_status;
  logic        done_o, busy_o;

  sdd_chain_dma #(.MAX_BYTES(MAXB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dma_en_i(dma_en),
    .is_write_i(is_write), .card_rd_ready_i(card_rd_ready),
    .desc_base_i(desc_base), .byte_count_i(byte_count), .block_size_i(block_size),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .st_clr_we_i(st_clr_we), .st_clr_mask_i(st_clr_mask),
    .dma_status_o(dma_status), .done_o(done_o), .busy_o(busy_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [7:0]  tx_log [0:255];
  int tx_cnt, rx_k, done_cnt, req_cnt, cyc, pat;
  int nchk, nerr;

  logic [31:0] szl [0:7];
  logic [31:0] d_st [0:4];
  logic [31:0] d_bf [0:4];
  int          d_n  [0:4];
  int          d_s0 [0:4];
  logic [7:0]  exp_b [0:255];
  int          exp_n, nd;

  // Memory and card models: decide at the falling edge, act at the next rising edge.
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    cyc = 0;
    forever begin
      logic tx_fire, rx_fire;
      @(negedge clk);
      if (mem_req) req_cnt++;
      if (done_o) done_cnt++;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[11:2]];
        mem_ack = 1'b1;
      end
      tx_fire = tx_valid && tx_ready;
      rx_fire = rx_valid && rx_ready;
      if (tx_fire) begin tx_log[tx_cnt[7:0]] = tx_data; tx_cnt++; end
      @(posedge clk); #1;
      if (rx_fire) rx_k++;
      rx_data  = 8'(rx_k * 7 + 3);
      cyc++;
      tx_ready = ((cyc + pat) % 3) != 0;
      rx_valid = ((cyc + pat) % 4) != 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic clear_status(input logic [9:0] m);
    @(posedge clk); #1 st_clr_we = 1'b1; st_clr_mask = m;
    @(posedge clk); #1 st_clr_we = 1'b0; st_clr_mask = '0;
    @(negedge clk);
  endtask

  task automatic run_case(input bit wr, input int bc, input int pi, input int last_at,
                          input string tag);
    int rem, e, bad, wbad;
    for (int i = 0; i < 5; i++) begin
      int dw, bw;
      dw = (32'h100 + 16 * i) / 4;
      bw = (32'h400 + 64 * i) / 4;
      d_st[i] = 32'h8000_0010 | ((i == 0) ? 32'h8 : 32'h0) | ((i == last_at) ? 32'h4 : 32'h0);
      d_bf[i] = 32'h400 + 64 * i + (i % 4);
      mem[dw]     = d_st[i];
      mem[dw + 1] = szl[(pi + i) % 8];
      mem[dw + 2] = d_bf[i];
      mem[dw + 3] = 32'h100 + 16 * (i + 1);
      for (int w = 0; w < 16; w++)
        mem[bw + w] = wr ? ((w + 16 * i + 1) * 32'h0123_4567) ^ 32'h5A5A_0000 : 32'hDEAD_BEEF;
    end
    // Expected walk
    rem = bc; exp_n = 0; nd = 0;
    for (int i = 0; i < 5; i++) begin
      int sz;
      sz = ((szl[(pi + i) % 8] == 0) || (szl[(pi + i) % 8] > MAXB)) ? MAXB : int'(szl[(pi + i) % 8]);
      d_n[i] = (sz < rem) ? sz : rem;
      d_s0[i] = exp_n;
      for (int b = 0; b < d_n[i]; b++) begin
        logic [31:0] wv;
        wv = mem[(32'h400 + 64 * i) / 4 + b / 4];
        exp_b[exp_n] = wr ? wv[8 * (b % 4) +: 8] : 8'(exp_n * 7 + 3);
        exp_n++;
      end
      rem -= d_n[i];
      nd = i + 1;
      if ((i == last_at) || (rem == 0)) break;
    end
    is_write = wr; byte_count = bc; desc_base = 32'h100; dma_en = 1'b1;
    block_size = 32'd512; card_rd_ready = 1'b1;
    tx_cnt = 0; rx_k = 0; done_cnt = 0; pat = pi + bc;
    pulse_start();
    for (int c = 0; c < 3000 && done_cnt == 0; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(done_cnt == 1, "R9", "completion pulses", done_cnt, 1);
    check((wr ? tx_cnt : rx_k) == exp_n, "R4", "bytes moved", wr ? tx_cnt : rx_k, exp_n);
    bad = 0;
    if (wr) begin
      for (int k = 0; k < exp_n && k < tx_cnt; k++) if (tx_log[k] != exp_b[k]) bad++;
    end else begin
      for (int i = 0; i < nd; i++)
        for (int w = 0; w * 4 < d_n[i]; w++) begin
          logic [31:0] ew;
          for (int b = 0; b < 4; b++)
            ew[8 * b +: 8] = (4 * w + b < d_n[i]) ? exp_b[d_s0[i] + 4 * w + b] : 8'h00;
          if (mem[(32'h400 + 64 * i) / 4 + w] != ew) bad++;
        end
    end
    check(bad == 0, tag, "data mismatches", bad, 0);
    wbad = 0;
    for (int i = 0; i < nd; i++)
      if (mem[(32'h100 + 16 * i) / 4] != (d_st[i] & 32'h7FFF_FFFF)) wbad++;
    check(wbad == 0, "R6", "writeback mismatches", wbad, 0);
    if (nd < 5)
      check(mem[(32'h100 + 16 * nd) / 4] == d_st[nd], "R7", "descriptor past end untouched",
            mem[(32'h100 + 16 * nd) / 4], d_st[nd]);
    check(dma_status == (wr ? 10'h101 : 10'h102), "R9", "status after walk",
          32'(dma_status), wr ? 32'h101 : 32'h102);
    clear_status(10'h3FF);
    check(dma_status == 10'h0, "R10", "status after full clear", 32'(dma_status), 0);
  endtask

  task automatic noop(input bit en, input int bc, input int bs, input bit wr, input bit rdy);
    dma_en = en; byte_count = bc; block_size = bs; is_write = wr; card_rd_ready = rdy;
    desc_base = 32'h100;
    req_cnt = 0; done_cnt = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    check(req_cnt == 0 && done_cnt == 0 && dma_status == 10'h0, "R8",
          "ignored start activity", req_cnt + done_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int bcs [0:9];
    nchk = 0; nerr = 0; tx_cnt = 0; rx_k = 0; done_cnt = 0; req_cnt = 0; pat = 0;
    szl[0] = 0; szl[1] = 1; szl[2] = 3; szl[3] = 4;
    szl[4] = 5; szl[5] = 16; szl[6] = 40; szl[7] = 32'hFFFF_FFFF;
    bcs = '{1, 2, 3, 4, 5, 7, 9, 16, 17, 33};
    for (int j = 0; j < 1024; j++) mem[j] = '0;
    rst_n = 1'b0; start = 1'b0; dma_en = 1'b0; is_write = 1'b0; card_rd_ready = 1'b0;
    desc_base = '0; byte_count = '0; block_size = '0; st_clr_we = 1'b0; st_clr_mask = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !mem_req && !tx_valid && !rx_ready && dma_status == 10'h0, "R12",
          "idle after reset", {busy_o, mem_req, tx_valid, rx_ready}, 0);

    noop(1'b0, 8, 512, 1'b1, 1'b1);
    noop(1'b1, 0, 512, 1'b1, 1'b1);
    noop(1'b1, 8, 0, 1'b1, 1'b1);
    noop(1'b1, 8, 512, 1'b0, 1'b0);

    run_case(1'b1, 16, 0, 4, "R2");
    run_case(1'b1, 20, 6, 4, "R3");
    run_case(1'b0, 20, 7, 4, "R3");
    run_case(1'b1, 60, 5, 1, "R7");

    for (int p = 0; p < 8; p++)
      for (int b = 0; b < 10; b++) run_case(1'b1, bcs[b], p, 4, "R1 R11");
    for (int p = 0; p < 8; p++)
      for (int b = 0; b < 10; b++) run_case(1'b0, bcs[b], p, 4, "R5");

    // Partial clear leaves the transmit bit
    run_case(1'b1, 9, 3, 4, "R1");
    pulse_start();
    for (int c = 0; c < 3000 && !done_o; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    clear_status(10'h100);
    check(dma_status == 10'h001, "R10", "partial clear", 32'(dma_status), 32'h1);
    clear_status(10'h3FF);
    check(dma_status == 10'h000, "R10", "final clear", 32'(dma_status), 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule